// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes for one parallel ATA channel. A single 32-bit timing word holds two sets of counts. One set is for data transfers (PIO or multiword DMA) and the other is for task-file register accesses. Each set has an active time, an inactive time and a first-cycle setup delay. A requester presents a cycle on a valid/ready handshake. Each cycle carries a direction and a flag that marks register accesses. The generator then walks through setup, active and recovery phases and reports the end of each cycle with a one-clock done pulse.

The sequencer has four states. IDLE holds both strobes high. SETUP waits out the setup delay. ACTIVE drives the selected strobe low. RECOVER holds the strobe high for the inactive time. The transitions are as follows:
- IDLE→SETUP: a request is taken and its setup count is non-zero.
- IDLE→ACTIVE: a request is taken and its setup count is zero.
- SETUP→ACTIVE: the setup delay is used up.
- ACTIVE→RECOVER: the active time is used up.
- RECOVER→ACTIVE: a new request is taken in the last recovery clock (back-to-back).
- RECOVER→IDLE: the recovery ends with no request pending.

Top module: `ata_strobe_gen`

## Requirements
- R1: While reset is asserted and while idle, rd_n and wr_n are high, busy is low and req_ready is high.
- R2: For a data access (req_regacc=0), the strobe stays low for word[8:4]+1 clocks and then high for word[3:0]+1 clocks before the cycle ends.
- R3: For a register access (req_regacc=1), the strobe stays low for word[17:13]+1 clocks and then high for word[12:9]+1 clocks. The data fields have no effect.
- R4: A request taken while idle waits a setup delay before the strobe falls. The delay is word[24:22] clocks for data accesses and word[27:25] clocks for register accesses, and a value of zero means no delay. The first strobe-low clock is the (setup+1)-th clock after the accepting edge.
- R5: A request taken in the last recovery clock of the previous cycle skips the setup delay, so its strobe falls on the very next clock.
- R6: cyc_done is high for exactly one clock, the last clock of the inactive phase. req_ready is high only while idle and in that clock.
- R7: req_write=1 drives only wr_n low and req_write=0 drives only rd_n low. The two strobes are never low together.
- R8: The timing word, direction and access type are captured when a request is accepted. Changes to the inputs afterwards do not alter the cycle in progress.
- R9: Bits 21:18 and 31:28 of the timing word have no effect on the strobes, done or busy.
- R10: busy is high from the clock after an accepted request until the clock after cyc_done, when no further request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Packed timing word |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_regacc | input | 1 | 1 = task-file register access, 0 = data access |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cyc_done | output | 1 | One-clock pulse at the end of each cycle |
| busy | output | 1 | A cycle is in progress |

## Verification
The hardest path to reach is RECOVER→ACTIVE. It is only taken if req_valid is already high in the single clock where cyc_done and req_ready rise. The stimulus therefore raises the request early and holds it through the whole first cycle. It then checks that the strobe falls on the next clock, even though the word asks for a non-zero setup delay. The sweep covers every active, inactive and setup count in a reduced range, both access types and both directions. After each acceptance the timing word is inverted, which exercises capture-at-accept in every run.

// File: rtl/ats_pkg.sv
package ats_pkg;
    localparam int ACT_W   = 5;
    localparam int INACT_W = 4;
    localparam int SETUP_W = 3;
    localparam int CNT_W   = ACT_W;
    localparam int WORD_W  = 32;

    // field positions inside the timing word
    localparam int D_INACT_LSB = 0;
    localparam int D_ACT_LSB   = 4;
    localparam int R_INACT_LSB = 9;
    localparam int R_ACT_LSB   = 13;
    localparam int D_SETUP_LSB = 22;
    localparam int R_SETUP_LSB = 25;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER
    } ats_state_e;

    typedef struct packed {
        logic [ACT_W-1:0]   act;
        logic [INACT_W-1:0] inact;
        logic [SETUP_W-1:0] setup;
    } ats_phase_t;
endpackage

// File: rtl/ats_unpack.sv
module ats_unpack
    import ats_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              regacc,
    output ats_phase_t        phase
);
    logic ign_unused;
    assign ign_unused = ^{word[31:28], word[21:18]};

    always_comb begin
        if (regacc) begin
            phase.act   = word[R_ACT_LSB   +: ACT_W];
            phase.inact = word[R_INACT_LSB +: INACT_W];
            phase.setup = word[R_SETUP_LSB +: SETUP_W];
        end else begin
            phase.act   = word[D_ACT_LSB   +: ACT_W];
            phase.inact = word[D_INACT_LSB +: INACT_W];
            phase.setup = word[D_SETUP_LSB +: SETUP_W];
        end
    end
endmodule

// File: rtl/ats_phase_cnt.sv
module ats_phase_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ats_fsm.sv
module ats_fsm
    import ats_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  ats_phase_t       phase_in,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             req_ready,
    output logic             rd_n,
    output logic             wr_n,
    output logic             cyc_done,
    output logic             busy
);
    ats_state_e st_q, st_d;
    ats_phase_t phase_q;
    logic       write_q;
    logic       take;

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            phase_q <= '0;
            write_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take) begin
                phase_q <= phase_in;
                write_q <= req_write;
            end
        end
    end

    // next state and counter loads
    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        take     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take     = 1'b1;
                    cnt_load = 1'b1;
                    if (phase_in.setup != '0) begin
                        st_d    = ST_SETUP;
                        cnt_val = CNT_W'(phase_in.setup - 1'b1);
                    end else begin
                        st_d    = ST_ACTIVE;
                        cnt_val = CNT_W'(phase_in.act);
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    st_d     = ST_ACTIVE;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(phase_q.act);
                end
            end
            ST_ACTIVE: begin
                if (cnt_zero) begin
                    st_d     = ST_RECOVER;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(phase_q.inact);
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) begin
                    if (req_valid) begin
                        take     = 1'b1;
                        st_d     = ST_ACTIVE;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(phase_in.act);
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        busy      = (st_q != ST_IDLE);
        cyc_done  = (st_q == ST_RECOVER) && cnt_zero;
        req_ready = (st_q == ST_IDLE) || cyc_done;
        rd_n      = !((st_q == ST_ACTIVE) && !write_q);
        wr_n      = !((st_q == ST_ACTIVE) && write_q);
    end
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_regacc,
    output logic              req_ready,
    output logic              rd_n,
    output logic              wr_n,
    output logic              cyc_done,
    output logic              busy
);
    ats_phase_t       phase_sel;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;

    ats_unpack u_unpack (
        .word   (cfg_word),
        .regacc (req_regacc),
        .phase  (phase_sel)
    );

    ats_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    ats_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .phase_in  (phase_sel),
        .cnt_zero  (cnt_zero),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .req_ready (req_ready),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cyc_done  (cyc_done),
        .busy      (busy)
    );
endmodule

// File: rtl/ats_chk.sv
module ats_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_n,
    input logic wr_n,
    input logic cyc_done,
    input logic busy
);
    // R7
    never_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    // R1
    idle_strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    // R6
    ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> req_ready);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cyc_done));
endmodule

bind ata_strobe_gen ats_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .cyc_done  (cyc_done),
    .busy      (busy)
);

// File: tb/tb_ata_strobe_gen.sv
`timescale 1ns/1ps
module tb_ata_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_regacc = 1'b0;
    logic        req_ready, rd_n, wr_n, cyc_done, busy;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    ata_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write), .req_regacc(req_regacc),
        .req_ready(req_ready), .rd_n(rd_n), .wr_n(wr_n),
        .cyc_done(cyc_done), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    // data timing at 3:0/8:4/24:22, register timing at 12:9/17:13/27:25
    function automatic logic [31:0] mk_word(input bit ra, input int s, input int l,
                                            input int h, input int junk);
        logic [31:0] w;
        int os, ol, oh;
        os = (s + 1) % 8; ol = (l + 5) % 32; oh = (h + 3) % 16;
        w = '0;
        if (ra) begin
            w[27:25] = 3'(s); w[17:13] = 5'(l); w[12:9] = 4'(h);
            w[24:22] = 3'(os); w[8:4] = 5'(ol); w[3:0] = 4'(oh);
        end else begin
            w[24:22] = 3'(s); w[8:4] = 5'(l); w[3:0] = 4'(h);
            w[27:25] = 3'(os); w[17:13] = 5'(ol); w[12:9] = 4'(oh);
        end
        w[31:28] = 4'(junk);       // R9 ignored bits
        w[21:18] = 4'(junk * 7);   // R9 ignored bits
        return w;
    endfunction

    task automatic run_one(input bit ra, input bit wr, input int s, input int l,
                           input int h, input int junk);
        int first_low, nlow, done_idx, wrong;
        string tg;
        tg = ra ? "R3" : "R2";
        first_low = -1; nlow = 0; done_idx = -1; wrong = 0;
        @(negedge clk);
        cfg_word = mk_word(ra, s, l, h, junk);
        req_regacc = ra; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_word = ~cfg_word;        // R8 change after accept
        req_regacc = ~ra; req_write = ~wr;
        for (int i = 0; i < 80; i++) begin
            if ((wr ? wr_n : rd_n) == 1'b0) begin
                if (first_low < 0) first_low = i;
                nlow++;
            end
            if ((wr ? rd_n : wr_n) == 1'b0) wrong++;
            if (cyc_done) begin
                done_idx = i;
                break;
            end
            @(negedge clk);
        end
        check({"R4 setup ", tg}, first_low, s);
        check({"R8 active ", tg}, nlow, l + 1);
        check({"R9 done index ", tg}, done_idx, s + l + 1 + h);
        check("R7 other strobe low", wrong, 0);
        @(negedge clk);
        check("R10 busy after done", int'(busy), 0);
    endtask

    initial begin
        int d;
        #1;
        // R1 during reset
        check("R1 rd_n in reset", int'(rd_n), 1);
        check("R1 wr_n in reset", int'(wr_n), 1);
        check("R1 busy in reset", int'(busy), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready idle", int'(req_ready), 1);
        check("R1 strobes idle", int'(rd_n & wr_n), 1);

        // R2 R3 R4 R7 R8 R9 R10 sweep
        for (int ra = 0; ra < 2; ra++)
            for (int wr = 0; wr < 2; wr++)
                for (int s = 0; s < 3; s++)
                    for (int l = 0; l < 4; l++)
                        for (int h = 0; h < 4; h++)
                            run_one(ra[0], wr[0], s, l, h, s * 5 + l * 3 + h + ra);

        // R5 R6 back-to-back, setup=2, act=1, inact=1
        @(negedge clk);
        cfg_word = mk_word(1'b0, 2, 1, 1, 0);
        req_regacc = 1'b0; req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        d = -1;
        for (int i = 0; i < 40; i++) begin
            if (cyc_done) begin d = i; break; end
            check("R6 ready low while busy", int'(req_ready), 0);
            @(negedge clk);
        end
        check("R6 first done index", d, 2 + 1 + 1 + 1);
        check("R6 ready in done clock", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 strobe low without setup", int'(wr_n), 0);
        check("R6 done single clock", int'(cyc_done), 0);
        check("R5 busy kept", int'(busy), 1);
        @(negedge clk);
        check("R5 active second clock", int'(wr_n), 0);
        @(negedge clk);
        check("R5 recovery", int'(wr_n), 1);
        @(negedge clk);
        check("R6 second done", int'(cyc_done), 1);
        @(negedge clk);
        check("R10 idle after chain", int'(busy), 0);
        check("R1 ready after chain", int'(req_ready), 1);

        finish_run();
    end
endmodule